// File: doc/BRIEF.md
# Sprite Scanline Evaluator

This block prepares the sprite draw list for the next display line. A start pulse latches the current line number, the attribute table page, the pattern half select and the sprite height mode. The block then walks a cached table of sprite Y coordinates, two entries per clock. It keeps the sprites whose vertical span covers the line that follows the current one. For each kept sprite it then reads the horizontal position byte and the tile number byte from video memory and forms the byte address of the pattern row that the line renderer needs.

The results come out one draw entry per accepted sprite, as an index, an X byte and a row address, strobed by a write enable. A count and a sticky overflow flag stay valid after the run. The flag is raised when more sprites cover the line than the list can hold, and it is cleared by a status read strobe. Reads of the Y cache and of video memory are combinational: the address goes out and the data is used in the same cycle.

The controller is a five-state machine. IDLE waits for start (IDLE→SCAN). SCAN tests one pair of cache entries per cycle and leaves on the last pair, on an end marker or on overflow. It goes to FETCH_X when at least one sprite was kept and to DONE otherwise. FETCH_X reads the X byte (FETCH_X→FETCH_T). FETCH_T reads the tile byte and emits the entry. It returns to FETCH_X for the next sprite or goes to DONE after the last one. DONE raises done for one cycle (DONE→IDLE).

Top module: `sprite_line_eval`

## Requirements
- R1: After reset, busy, done, draw_we, draw_count and overflow are all 0.
- R2: A start pulse in IDLE latches the inputs. The line tested is cur_line + 1 taken modulo 256, so cur_line 255 tests line 0. Input changes after start do not affect the run.
- R3: A sprite with coordinate Y covers tested line L when Y ≤ L and L < Y + H. The sum is formed without wrapping. H is 8 when tall_mode is 0 and 16 when tall_mode is 1.
- R4: In each SCAN cycle, ycache_addr holds the pair number p. ycache_data[7:0] is the Y of sprite 2p and ycache_data[15:8] is the Y of sprite 2p+1. The scan covers sprites 0 to 63 and ends after pair 31.
- R5: A Y value of 0xD0 ends the scan, and that sprite and every later one are ignored. When the marker is in the upper half of a pair, the lower sprite of that pair is still tested.
- R6: Draw entries are emitted in ascending sprite number. draw_idx counts 0 to draw_count−1, with one draw_we cycle per entry.
- R7: The X byte of sprite n is read at attr_page×256 + 0x80 + 2n, and its tile byte is read at the next address.
- R8: draw_addr = tile×32 + (L − Y)×4, plus 0x2000 when pat_hi_sel is 1.
- R9: At most MAX_PER_LINE (8) sprites are kept. A covering sprite found with the list full sets overflow and ends the scan.
- R10: overflow stays set across later runs until a cycle with status_rd high in which no new overflow is detected. A new overflow in the same cycle as status_rd wins.
- R11: done is high for exactly one cycle at the end of every run. A run with no covering sprite ends with draw_count 0 and no draw_we.
- R12: A start pulse while busy is ignored: the run in progress is unchanged and no second run follows.
- R13: Exactly MAX_PER_LINE covering sprites fill the list without setting overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin evaluation for the next line |
| cur_line | input | 8 | Current line number |
| attr_page | input | 6 | Attribute table page (address bits 13:8) |
| pat_hi_sel | input | 1 | Selects the upper pattern half (+0x2000) |
| tall_mode | input | 1 | Sprite height 16 when 1, 8 when 0 |
| status_rd | input | 1 | Status read strobe, clears overflow |
| ycache_addr | output | 5 | Y cache pair address |
| ycache_data | input | 16 | Two Y bytes of the addressed pair |
| mem_addr | output | 14 | Video memory byte address |
| mem_data | input | 8 | Video memory read data |
| draw_we | output | 1 | Draw entry valid |
| draw_idx | output | 3 | Draw list slot |
| draw_x | output | 8 | Sprite X byte |
| draw_addr | output | 14 | Pattern row byte address |
| draw_count | output | 4 | Sprites kept in the last run |
| overflow | output | 1 | Sticky too-many-sprites flag |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The flag update is where two functions can meet in one cycle: the scan can detect an excess sprite in the same cycle in which a status read asks to clear the flag. The bench forces this by holding status_rd high from the start pulse and releasing it at the first falling edge where overflow reads 1. It also confirms that the flag was first seen cleared during the same run. Only a design in which detection wins ends that run with overflow at 1. A later single read pulse in IDLE must then clear the flag.

// File: rtl/sle_pkg.sv
package sle_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FETCH_X,
        ST_FETCH_T,
        ST_DONE
    } sle_state_t;

    // Y value that marks the end of the active sprite table
    localparam logic [7:0] Y_END_MARK = 8'hD0;

    // Row offset inside a sprite is at most 15 (16-line sprites)
    localparam int ROW_W = 4;

endpackage

// File: rtl/sle_hit_check.sv
module sle_hit_check
    import sle_pkg::*;
(
    input  logic [7:0]       y_val,
    input  logic [7:0]       line_cmp,
    input  logic             tall,
    output logic             hit,
    output logic             term,
    output logic [ROW_W-1:0] row
);
    logic [8:0] y_limit;

    always_comb begin
        // span end is formed in 9 bits so a sprite near the bottom never wraps
        y_limit = {1'b0, y_val} + (tall ? 9'd16 : 9'd8);
        hit     = (y_val <= line_cmp) && ({1'b0, line_cmp} < y_limit);
        term    = (y_val == Y_END_MARK);
        // difference is below 16 whenever hit is set, so low bits suffice
        row     = line_cmp[ROW_W-1:0] - y_val[ROW_W-1:0];
    end

endmodule

// File: rtl/sle_cand_list.sv
module sle_cand_list
    import sle_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 6,
    parameter int PW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr0_en,
    input  logic [PW-1:0]    wr0_pos,
    input  logic [IW-1:0]    wr0_idx,
    input  logic [ROW_W-1:0] wr0_row,
    input  logic             wr1_en,
    input  logic [PW-1:0]    wr1_pos,
    input  logic [IW-1:0]    wr1_idx,
    input  logic [ROW_W-1:0] wr1_row,
    input  logic [PW-1:0]    rd_pos,
    output logic [IW-1:0]    rd_idx,
    output logic [ROW_W-1:0] rd_row
);
    logic [IW-1:0]    idx_q [DEPTH];
    logic [ROW_W-1:0] row_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                idx_q[e] <= '0;
                row_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (wr0_en && (wr0_pos == PW'(e))) begin
                    idx_q[e] <= wr0_idx;
                    row_q[e] <= wr0_row;
                end else if (wr1_en && (wr1_pos == PW'(e))) begin
                    idx_q[e] <= wr1_idx;
                    row_q[e] <= wr1_row;
                end
            end
        end
    end

    always_comb begin
        rd_idx = '0;
        rd_row = '0;
        if (int'(rd_pos) < DEPTH) begin
            rd_idx = idx_q[rd_pos];
            rd_row = row_q[rd_pos];
        end
    end

    // R9: two accepted sprites of one pair never target the same slot
    // R9
    wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && wr1_en) |-> (wr0_pos != wr1_pos));

endmodule

// File: rtl/sle_addr_gen.sv
module sle_addr_gen
    import sle_pkg::*;
#(
    parameter int IW = 6
) (
    input  logic [5:0]       attr_page,
    input  logic [IW-1:0]    spr_idx,
    input  logic [7:0]       tile,
    input  logic [ROW_W-1:0] row,
    input  logic             pat_hi,
    output logic [13:0]      x_addr,
    output logic [13:0]      t_addr,
    output logic [13:0]      row_addr
);
    logic [5:0] idx6;

    always_comb begin
        idx6     = 6'(spr_idx);
        // page*256 + 0x80 + 2n, no carry possible for n < 64
        x_addr   = {attr_page, 1'b1, idx6, 1'b0};
        t_addr   = {attr_page, 1'b1, idx6, 1'b1};
        row_addr = {pat_hi, 13'd0}
                 + {1'b0, tile, 5'd0}
                 + {8'd0, row, 2'b00};
    end

endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
    import sle_pkg::*;
#(
    parameter int MAX_PER_LINE = 8,
    parameter int SPR_TOTAL    = 64
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [7:0]                             cur_line,
    input  logic [5:0]                             attr_page,
    input  logic                                   pat_hi_sel,
    input  logic                                   tall_mode,
    input  logic                                   status_rd,
    output logic [$clog2(SPR_TOTAL/2)-1:0]         ycache_addr,
    input  logic [15:0]                            ycache_data,
    output logic [13:0]                            mem_addr,
    input  logic [7:0]                             mem_data,
    output logic                                   draw_we,
    output logic [$clog2(MAX_PER_LINE)-1:0]        draw_idx,
    output logic [7:0]                             draw_x,
    output logic [13:0]                            draw_addr,
    output logic [$clog2(MAX_PER_LINE+1)-1:0]      draw_count,
    output logic                                   overflow,
    output logic                                   busy,
    output logic                                   done
);
    localparam int PAIRS  = SPR_TOTAL / 2;
    localparam int PAIR_W = $clog2(PAIRS);
    localparam int IDX_W  = PAIR_W + 1;
    localparam int POS_W  = $clog2(MAX_PER_LINE);
    localparam int CNT_W  = $clog2(MAX_PER_LINE + 1);

    sle_state_t state_q, state_d;

    logic [PAIR_W-1:0] pair_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [POS_W-1:0]  fpos_q;
    logic [7:0]        x_q;
    logic [7:0]        line_q;
    logic              tall_q;
    logic              pat_q;
    logic [5:0]        page_q;
    logic              ovf_q;

    // ---------------- pair test ----------------
    logic [1:0]       hit_raw;
    logic [1:0]       term_raw;
    logic [ROW_W-1:0] row_s [2];
    logic [IDX_W-1:0] idx_s [2];

    for (genvar s = 0; s < 2; s++) begin : g_hit
        sle_hit_check u_hit (
            .y_val    (ycache_data[8*s +: 8]),
            .line_cmp (line_q),
            .tall     (tall_q),
            .hit      (hit_raw[s]),
            .term     (term_raw[s]),
            .row      (row_s[s])
        );
        assign idx_s[s] = {pair_q, 1'(s)};
    end

    logic             in_scan;
    logic             hit_a, hit_b, acc_a, acc_b, ovf_now, scan_end;
    logic [CNT_W-1:0] free_slots, cnt_after;

    always_comb begin
        in_scan    = (state_q == ST_SCAN);
        hit_a      = in_scan && hit_raw[0] && !term_raw[0];
        hit_b      = in_scan && hit_raw[1] && !term_raw[0] && !term_raw[1];
        free_slots = CNT_W'(MAX_PER_LINE) - cnt_q;
        acc_a      = hit_a && (free_slots != '0);
        acc_b      = hit_b && (free_slots > CNT_W'(acc_a));
        ovf_now    = (hit_a && !acc_a) || (hit_b && !acc_b);
        cnt_after  = cnt_q + CNT_W'(acc_a) + CNT_W'(acc_b);
        scan_end   = in_scan && (ovf_now || term_raw[0] || term_raw[1]
                                 || (pair_q == PAIR_W'(PAIRS - 1)));
    end

    // ---------------- candidate storage ----------------
    logic [IDX_W-1:0] rd_idx;
    logic [ROW_W-1:0] rd_row;

    sle_cand_list #(
        .DEPTH (MAX_PER_LINE),
        .IW    (IDX_W),
        .PW    (POS_W)
    ) u_list (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr0_en  (acc_a),
        .wr0_pos (POS_W'(cnt_q)),
        .wr0_idx (idx_s[0]),
        .wr0_row (row_s[0]),
        .wr1_en  (acc_b),
        .wr1_pos (POS_W'(cnt_q + CNT_W'(acc_a))),
        .wr1_idx (idx_s[1]),
        .wr1_row (row_s[1]),
        .rd_pos  (fpos_q),
        .rd_idx  (rd_idx),
        .rd_row  (rd_row)
    );

    // ---------------- address generation ----------------
    logic [13:0] x_addr, t_addr, row_addr;

    sle_addr_gen #(.IW(IDX_W)) u_addr (
        .attr_page (page_q),
        .spr_idx   (rd_idx),
        .tile      (mem_data),
        .row       (rd_row),
        .pat_hi    (pat_q),
        .x_addr    (x_addr),
        .t_addr    (t_addr),
        .row_addr  (row_addr)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_SCAN;
            ST_SCAN:    if (scan_end)
                            state_d = (cnt_after == '0) ? ST_DONE : ST_FETCH_X;
            ST_FETCH_X: state_d = ST_FETCH_T;
            ST_FETCH_T: state_d = ((CNT_W'(fpos_q) + CNT_W'(1)) == cnt_q)
                                  ? ST_DONE : ST_FETCH_X;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
            cnt_q  <= '0;
            fpos_q <= '0;
            x_q    <= '0;
            line_q <= '0;
            tall_q <= 1'b0;
            pat_q  <= 1'b0;
            page_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && start) begin
                line_q <= cur_line + 8'd1;
                tall_q <= tall_mode;
                pat_q  <= pat_hi_sel;
                page_q <= attr_page;
                pair_q <= '0;
                cnt_q  <= '0;
                fpos_q <= '0;
            end
            if (in_scan) begin
                pair_q <= pair_q + PAIR_W'(1);
                cnt_q  <= cnt_after;
            end
            if (state_q == ST_FETCH_X) x_q <= mem_data;
            if (state_q == ST_FETCH_T) fpos_q <= fpos_q + POS_W'(1);
            // detection takes precedence over a status read
            if (ovf_now)        ovf_q <= 1'b1;
            else if (status_rd) ovf_q <= 1'b0;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ycache_addr = pair_q;
        mem_addr    = (state_q == ST_FETCH_T) ? t_addr : x_addr;
        draw_we     = (state_q == ST_FETCH_T);
        draw_idx    = fpos_q;
        draw_x      = x_q;
        draw_addr   = row_addr;
        draw_count  = cnt_q;
        overflow    = ovf_q;
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
    end

    // ---------------- assertions ----------------
    // R9
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        draw_count <= CNT_W'(MAX_PER_LINE));

    // R9
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !$past(overflow)) |-> $past(state_q == ST_SCAN));

    // R10
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overflow) && !$past(status_rd)) |-> overflow);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    draw_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        draw_we |-> (CNT_W'(draw_idx) < draw_count));

    // R12
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(line_q));

endmodule

// File: tb/sprite_line_eval_test.sv
module sprite_line_eval_test;

    localparam int MAXL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cur_line = 8'd0;
    logic [5:0]  attr_page = 6'd0;
    logic        pat_hi_sel = 1'b0;
    logic        tall_mode = 1'b0;
    logic        status_rd = 1'b0;
    logic [4:0]  ycache_addr;
    logic [15:0] ycache_data;
    logic [13:0] mem_addr;
    logic [7:0]  mem_data;
    logic        draw_we;
    logic [2:0]  draw_idx;
    logic [7:0]  draw_x;
    logic [13:0] draw_addr;
    logic [3:0]  draw_count;
    logic        overflow;
    logic        busy;
    logic        done;

    always #2 clk = ~clk;

    logic [7:0] ycl  [64];
    logic [7:0] vram [16384];

    assign ycache_data = {ycl[{ycache_addr, 1'b1}], ycl[{ycache_addr, 1'b0}]};
    assign mem_data    = vram[mem_addr];

    sprite_line_eval uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_line(cur_line),
        .attr_page(attr_page), .pat_hi_sel(pat_hi_sel), .tall_mode(tall_mode),
        .status_rd(status_rd), .ycache_addr(ycache_addr), .ycache_data(ycache_data),
        .mem_addr(mem_addr), .mem_data(mem_data), .draw_we(draw_we),
        .draw_idx(draw_idx), .draw_x(draw_x), .draw_addr(draw_addr),
        .draw_count(draw_count), .overflow(overflow), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    int got_n = 0;
    int got_x [MAXL];
    int got_a [MAXL];

    int exp_n;
    bit exp_ovf_now;
    bit m_ovf = 1'b0;
    int exp_x [MAXL];
    int exp_a [MAXL];

    always @(negedge clk) begin
        if (rst_n && draw_we) begin
            got_x[draw_idx] <= int'(draw_x);
            got_a[draw_idx] <= int'(draw_addr);
            got_n <= got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic clear_y();
        for (int i = 0; i < 64; i++) ycl[i] = 8'hE0;
    endtask

    // expected draw list from the requirements (R2 R3 R5 R7 R8 R9)
    task automatic ref_eval(input logic [7:0] cur, input logic [5:0] page,
                            input bit pat, input bit tall);
        int ln;
        int sz;
        ln = (int'(cur) + 1) & 255;
        sz = tall ? 16 : 8;
        exp_n = 0;
        exp_ovf_now = 1'b0;
        for (int i = 0; i < 64; i++) begin
            int y;
            int xa;
            y = int'(ycl[i]);
            if (y == 'hD0) break;
            if (y <= ln && ln < y + sz) begin
                if (exp_n == MAXL) begin
                    exp_ovf_now = 1'b1;
                    break;
                end
                xa = int'(page) * 256 + 'h80 + 2 * i;
                exp_x[exp_n] = int'(vram[xa]);
                exp_a[exp_n] = int'(vram[xa + 1]) * 32 + (pat ? 'h2000 : 0) + (ln - y) * 4;
                exp_n++;
            end
        end
    endtask

    task automatic run_line(input logic [7:0] cur, input logic [5:0] page,
                            input bit pat, input bit tall,
                            input bit rd_hold, input bit extra_start,
                            input string tag);
        int  cyc;
        bit  saw_clear;
        ref_eval(cur, page, pat, tall);
        got_n      = 0;
        cur_line   = cur;
        attr_page  = page;
        pat_hi_sel = pat;
        tall_mode  = tall;
        status_rd  = rd_hold;
        saw_clear  = 1'b0;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            if (extra_start && cyc == 3) begin
                start    = 1'b1;           // R12 start while busy
                cur_line = cur + 8'd40;    // R2 late input change
            end else begin
                start = 1'b0;
            end
            if (rd_hold) begin
                if (!overflow) saw_clear = 1'b1;
                if (overflow && saw_clear) status_rd = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start     = 1'b0;
        status_rd = 1'b0;
        chk(cyc < 2000, {tag, " R11 done reached"}, cyc, 0);
        if (rd_hold) begin
            chk(saw_clear, {tag, " R10 flag cleared by read"}, int'(saw_clear), 1);
            m_ovf = exp_ovf_now;
        end else begin
            m_ovf = m_ovf | exp_ovf_now;
        end
        @(negedge clk);
        chk(!done, {tag, " R11 done one cycle"}, int'(done), 0);
        chk(!busy, {tag, " R12 idle after run"}, int'(busy), 0);
        chk(int'(draw_count) == exp_n, {tag, " R9 count"}, int'(draw_count), exp_n);
        chk(got_n == exp_n, {tag, " R6 entries emitted"}, got_n, exp_n);
        chk(overflow == m_ovf, {tag, " R10 overflow"}, int'(overflow), int'(m_ovf));
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            chk(got_x[k] == exp_x[k], {tag, " R7 x byte"}, got_x[k], exp_x[k]);
            chk(got_a[k] == exp_a[k], {tag, " R8 row addr"}, got_a[k], exp_a[k]);
        end
    endtask

    task automatic t_reset();
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(!done, "R1 done", int'(done), 0);
        chk(!draw_we, "R1 draw_we", int'(draw_we), 0);
        chk(draw_count == 0, "R1 count", int'(draw_count), 0);
        chk(!overflow, "R1 overflow", int'(overflow), 0);
    endtask

    task automatic t_basic();
        clear_y();
        ycl[1] = 8'd10;   // covers 10..17, row 7 of line 17
        ycl[4] = 8'd14;   // row 3
        ycl[9] = 8'd3;    // 3..10, misses
        run_line(8'd16, 6'h05, 1'b0, 1'b0, 1'b0, 1'b0, "basic R3 R6");
        chk(draw_count == 4'd2, "basic R3 literal count", int'(draw_count), 2);
    endtask

    task automatic t_tall_last();
        clear_y();
        ycl[63] = 8'h20;  // last pair upper half, row 15 with tall
        ycl[0]  = 8'h28;  // row 7
        run_line(8'h2E, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b0, "tall R4 R8");
        chk(draw_count == 4'd2, "tall R4 literal count", int'(draw_count), 2);
        // same table with short sprites: only sprite 0 covers line 0x2F
        run_line(8'h2E, 6'h3F, 1'b1, 1'b0, 1'b0, 1'b0, "short R3");
        chk(draw_count == 4'd1, "short R3 literal count", int'(draw_count), 1);
    endtask

    task automatic t_wrap();
        clear_y();
        ycl[6] = 8'h00;   // covers line 0
        ycl[7] = 8'hF8;   // tall span 0xF8..0x107 must not wrap to line 0
        run_line(8'hFF, 6'h12, 1'b0, 1'b1, 1'b0, 1'b0, "wrap R2 R3");
        chk(draw_count == 4'd1, "wrap R2 literal count", int'(draw_count), 1);
        run_line(8'hFE, 6'h12, 1'b0, 1'b1, 1'b0, 1'b0, "bottom R3");
        chk(draw_count == 4'd1, "bottom R3 literal count", int'(draw_count), 1);
    endtask

    task automatic t_term();
        clear_y();
        ycl[2] = 8'h40;
        ycl[4] = 8'h41;
        ycl[5] = 8'hD0;   // marker in upper half: sprite 4 still counts
        ycl[6] = 8'h42;
        run_line(8'h44, 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, "term-hi R5");
        chk(draw_count == 4'd2, "term-hi R5 literal count", int'(draw_count), 2);
        ycl[5] = 8'h43;
        ycl[4] = 8'hD0;   // marker in lower half: sprite 5 ignored
        run_line(8'h44, 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, "term-lo R5");
        chk(draw_count == 4'd1, "term-lo R5 literal count", int'(draw_count), 1);
    endtask

    task automatic t_empty();
        clear_y();
        run_line(8'h10, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, "empty R11");
        chk(got_n == 0, "empty R11 no draw_we", got_n, 0);
    endtask

    task automatic t_full();
        clear_y();
        for (int i = 0; i < MAXL; i++) ycl[3 + 5 * i] = 8'(8'h60 + i % 4);
        run_line(8'h63, 6'h2A, 1'b1, 1'b0, 1'b0, 1'b0, "full R13");
        chk(!overflow, "full R13 no overflow", int'(overflow), 0);
    endtask

    task automatic t_overflow();
        clear_y();
        for (int i = 0; i < 10; i++) ycl[2 * i + 1] = 8'h70;
        run_line(8'h71, 6'h08, 1'b0, 1'b1, 1'b0, 1'b0, "ovf R9");
        chk(overflow, "ovf R9 flag", int'(overflow), 1);
        clear_y();
        run_line(8'h71, 6'h08, 1'b0, 1'b1, 1'b0, 1'b0, "sticky R10");
        chk(overflow, "sticky R10 kept", int'(overflow), 1);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        m_ovf = 1'b0;
        chk(!overflow, "read R10 clears", int'(overflow), 0);
    endtask

    task automatic t_collide();
        // two sprites of the last accepted pair exceed the list by one
        clear_y();
        for (int i = 0; i < 9; i++) ycl[i] = 8'h30;
        m_ovf = 1'b1;
        run_line(8'h30, 6'h10, 1'b0, 1'b0, 1'b1, 1'b0, "same-cycle R10");
        chk(overflow, "same-cycle R10 set wins", int'(overflow), 1);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        m_ovf = 1'b0;
        chk(!overflow, "same-cycle R10 later clear", int'(overflow), 0);
    endtask

    task automatic t_busy_start();
        clear_y();
        ycl[60] = 8'h20;
        ycl[61] = 8'h48;  // would match only the late line value
        run_line(8'h21, 6'h33, 1'b0, 1'b0, 1'b0, 1'b1, "busy R12");
        chk(draw_count == 4'd1, "busy R12 literal count", int'(draw_count), 1);
    endtask

    initial begin
        for (int a = 0; a < 16384; a++) vram[a] = 8'((a * 13) ^ (a >> 6));
        clear_y();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_tall_last();
        t_wrap();
        t_term();
        t_empty();
        t_full();
        t_overflow();
        t_collide();
        t_busy_start();
        summary();
        $finish;
    end

endmodule